// File: doc/BRIEF.md
# Transition-Coded Isolation Link Transmitter

This block is the sending half of a one-way, multi-channel logic link that crosses an isolation barrier. It does not stream raw levels. Each input line is synchronised and filtered, and every accepted change of level becomes a short command: the channel number and the new level ("drive high" or "drive low"). The receiving side only has to latch that level for the named channel.

Commands for edges alone cannot repair a receiver that lost its state after power-up or a disturbance. A background scan therefore runs on a fixed period. For every channel that did not change during the last scan window, it reissues a level command carrying the present level. This bounds the recovery time to between one and two scan periods. A local enable freezes the input stage. When the enable returns, every channel is reissued with its present pin level.

Commands leave through a single valid/ready port. Edge commands are served before refresh commands. Within each kind, lower channel numbers go first. At most one command is waiting per channel, and it is always sent with the level that is current when it is granted.

Top module: `edge_link_tx`

## Requirements
- R1: The block carries NUM_CH independent channels (default 5). Each command is presented as `cmd_ch_o` (channel index, CH_W bits, default 3) and `cmd_lvl_o` (1 = drive high, 0 = drive low). A command transfers on a clock edge where `cmd_valid_o` and `cmd_ready_i` are both 1.
- R2: An accepted rise of a channel's level produces one command with level 1 for that channel. An accepted fall produces one command with level 0. A steady level produces no edge command.
- R3: A new pin level must stay unchanged for MIN_PULSE consecutive clocks after the two-flop synchroniser before it is accepted. A shorter pulse produces no command.
- R4: Every REFRESH_CYCLES clocks, each channel that had no accepted transition in the window just ended receives one command carrying its current level.
- R5: A channel with at least one accepted transition in a scan window receives no refresh command for that window.
- R6: While `en_i` is 0, pin changes are ignored. Each channel keeps its last accepted level, and any command sent carries that held level.
- R7: On the first clock with `en_i` back at 1, every channel takes its present synchronised pin level without filtering. All channels are then sent with those levels, in ascending channel order.
- R8: During reset `cmd_valid_o` is 0. After reset, a refresh of all channels is pending, and channel 0 is offered first.
- R9: Pending edge commands are granted before pending refresh commands. Among pending channels of the same kind, the lowest index is granted first.
- R10: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, `cmd_valid_o`, `cmd_ch_o` and `cmd_lvl_o` hold their values.
- R11: A channel has at most one pending command. Several transitions that occur before it is granted collapse into one command carrying the level current at grant time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Side enable; 0 freezes the input stage |
| pins_i | input | NUM_CH | Asynchronous logic inputs, one per channel |
| cmd_ready_i | input | 1 | Downstream accepts the presented command |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_ch_o | output | CH_W | Channel index of the presented command |
| cmd_lvl_o | output | 1 | Level to drive on that channel |

## Verification
The bench builds the block with five channels, MIN_PULSE of 3 and REFRESH_CYCLES of 400. These values let a two-clock glitch and a three-clock pulse sit on either side of the filter threshold. Several full scan windows then fit into a short run, so refresh counts per channel and the silence of a busy channel can both be measured. A 40-clock toggle period keeps one channel active in every window. Stalls of about 30 clocks expose how pending commands collapse without reaching a scan boundary in most runs.

// File: rtl/lnk_tx_pkg.sv
// Shared definitions for the transition-coded link transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package lnk_tx_pkg;

    // Which kind of pending command won arbitration in a cycle.
    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_EDGE    = 2'd1,
        PICK_REFRESH = 2'd2
    } pick_e;

    // Bit width able to hold the values 0 .. n-1 (at least one bit).
    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lnk_tx_front.sv
// Per-channel input stage: two-flop synchroniser, minimum-width filter,
// enable freeze and edge pulse.
// Assumes: MIN_PULSE >= 1; en_rise_i is high only on the first enabled cycle.
module lnk_tx_front #(
    parameter int MIN_PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    input  logic en_rise_i,
    output logic lvl_o,
    output logic edge_o
);
    import lnk_tx_pkg::*;

    localparam int CW = idx_w(MIN_PULSE);
    localparam logic [CW-1:0] HOLD_LAST = CW'(MIN_PULSE - 1);

    logic [1:0]    sync_q;
    logic          sync_lvl;
    logic [CW-1:0] stable_cnt;

    assign sync_lvl = sync_q[1];

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pin_i};
    end

    // Accept a new level after it has been stable MIN_PULSE clocks; freeze when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o      <= 1'b0;
            edge_o     <= 1'b0;
            stable_cnt <= '0;
        end else begin
            edge_o <= 1'b0;
            if (en_rise_i) begin
                lvl_o      <= sync_lvl;
                stable_cnt <= '0;
            end else if (!en_i || (sync_lvl == lvl_o)) begin
                stable_cnt <= '0;
            end else if (stable_cnt == HOLD_LAST) begin
                lvl_o      <= sync_lvl;
                edge_o     <= 1'b1;
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end

    // R6: a disabled stage never moves its held level.
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(lvl_o));

    // R2: an edge pulse always coincides with a real level change.
    assert_edge_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> !$stable(lvl_o));

endmodule

// File: rtl/lnk_tx_refresh.sv
// Background scan: every PERIOD clocks, requests a level refresh for each
// channel that showed no accepted transition during the window.
// Assumes: PERIOD >= 2; edge_i pulses one clock per accepted transition.
module lnk_tx_refresh #(
    parameter int NUM_CH = 5,
    parameter int PERIOD = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] edge_i,
    output logic [NUM_CH-1:0] req_o
);
    import lnk_tx_pkg::*;

    localparam int TW = idx_w(PERIOD);
    localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD - 1);

    logic [TW-1:0]     tick_q;
    logic [NUM_CH-1:0] busy_q;

    // Run the window timer, track activity and emit refresh requests at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            busy_q <= '0;
            req_o  <= '0;
        end else begin
            req_o <= '0;
            if (tick_q == LAST_TICK) begin
                tick_q <= '0;
                req_o  <= ~(busy_q | edge_i);
                busy_q <= '0;
            end else begin
                tick_q <= tick_q + 1'b1;
                busy_q <= busy_q | edge_i;
            end
        end
    end

    // R4: the window timer stays inside its period.
    assert_tick_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= LAST_TICK);

    // R4: refresh requests are single-cycle pulses, once per window.
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_o) |=> !(|req_o));

endmodule

// File: rtl/lnk_tx_arb.sv
// Pending-command store and arbiter with a registered valid/ready output.
// Edge commands beat refresh commands; lowest index wins within a kind.
// Assumes: lvl_i already reflects any edge flagged on edge_i.
module lnk_tx_arb #(
    parameter int NUM_CH = 5,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] edge_i,
    input  logic [NUM_CH-1:0] ref_i,
    input  logic              ref_all_i,
    input  logic [NUM_CH-1:0] lvl_i,
    input  logic              cmd_ready_i,
    output logic              cmd_valid_o,
    output logic [CH_W-1:0]   cmd_ch_o,
    output logic              cmd_lvl_o
);
    import lnk_tx_pkg::*;

    logic [NUM_CH-1:0] pend_edge_q, pend_ref_q;
    logic [NUM_CH-1:0] grant;
    logic [CH_W-1:0]   grant_idx;
    pick_e             pick;
    logic              load;

    // Pick the lowest pending edge channel, else the lowest pending refresh channel.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        pick      = PICK_NONE;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_ref_q[i]) begin
                grant_idx = CH_W'(i);
                pick      = PICK_REFRESH;
            end
        end
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_edge_q[i]) begin
                grant_idx = CH_W'(i);
                pick      = PICK_EDGE;
            end
        end
        if (pick != PICK_NONE) grant[grant_idx] = 1'b1;
    end

    assign load = !cmd_valid_o || cmd_ready_i;

    // Record new requests and retire the granted channel of both kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_edge_q <= '0;
            pend_ref_q  <= '1;
        end else begin
            pend_edge_q <= (pend_edge_q | edge_i) & ~(load ? grant : '0);
            pend_ref_q  <= (pend_ref_q | ref_i | {NUM_CH{ref_all_i}})
                           & ~(load ? grant : '0);
        end
    end

    // Present the granted command, holding it until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_ch_o    <= '0;
            cmd_lvl_o   <= 1'b0;
        end else if (load) begin
            cmd_valid_o <= (pick != PICK_NONE);
            if (pick != PICK_NONE) begin
                cmd_ch_o  <= grant_idx;
                cmd_lvl_o <= lvl_i[grant_idx];
            end
        end
    end

    // R9: at most one channel granted per cycle.
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: a stalled command holds still.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_ch_o) && $stable(cmd_lvl_o)));

endmodule

// File: rtl/edge_link_tx.sv
// Top of the transition-coded link transmitter: per-channel input stages,
// background refresh scan and command arbiter.
// Assumes: en_i and cmd_ready_i are synchronous to clk; pins_i may be asynchronous.
module edge_link_tx #(
    parameter int NUM_CH         = 5,
    parameter int CH_W           = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int MIN_PULSE      = 4,
    parameter int REFRESH_CYCLES = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [NUM_CH-1:0] pins_i,
    input  logic              cmd_ready_i,
    output logic              cmd_valid_o,
    output logic [CH_W-1:0]   cmd_ch_o,
    output logic              cmd_lvl_o
);
    logic              en_q;
    logic              en_rise;
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] edge_pulse;
    logic [NUM_CH-1:0] ref_req;

    // Remember last cycle's enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_i;
    end

    assign en_rise = en_i && !en_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_front
        lnk_tx_front #(.MIN_PULSE(MIN_PULSE)) u_front (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pins_i[g]),
            .en_i      (en_i),
            .en_rise_i (en_rise),
            .lvl_o     (lvl[g]),
            .edge_o    (edge_pulse[g])
        );
    end

    lnk_tx_refresh #(.NUM_CH(NUM_CH), .PERIOD(REFRESH_CYCLES)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_pulse),
        .req_o  (ref_req)
    );

    lnk_tx_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edge_pulse),
        .ref_i       (ref_req),
        .ref_all_i   (en_rise),
        .lvl_i       (lvl),
        .cmd_ready_i (cmd_ready_i),
        .cmd_valid_o (cmd_valid_o),
        .cmd_ch_o    (cmd_ch_o),
        .cmd_lvl_o   (cmd_lvl_o)
    );

    // R1: the presented channel index is always a real channel.
    assert_ch_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (int'(cmd_ch_o) < NUM_CH));

endmodule

// File: tb/edge_link_tx_tb.sv
// Scoreboard bench: drivers queue expected edge commands, a monitor pops and
// compares accepted commands; refreshes must repeat a known level.
module edge_link_tx_tb;
    localparam int NCH = 5;
    localparam int CHW = 3;
    localparam int MINP = 3;
    localparam int PER = 400;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b1;
    logic [NCH-1:0] pins = '0;
    logic           ready = 1'b0;
    logic           vld;
    logic [CHW-1:0] ch;
    logic           lv;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    int  exp_q[$];
    int  lg_ch[$];
    int  lg_lv[$];
    bit  model [NCH];
    bit  last_sent [NCH];

    always #4 clk = ~clk;

    edge_link_tx #(.NUM_CH(NCH), .CH_W(CHW), .MIN_PULSE(MINP), .REFRESH_CYCLES(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .pins_i(pins), .cmd_ready_i(ready),
        .cmd_valid_o(vld), .cmd_ch_o(ch), .cmd_lvl_o(lv)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: log each accepted command and score it.
    always @(negedge clk) begin
        if (rst_n && vld && ready) begin
            lg_ch.push_back(int'(ch));
            lg_lv.push_back(int'(lv));
            if (exp_q.size() > 0 && exp_q[0] == int'(ch) * 2 + int'(lv)) begin
                void'(exp_q.pop_front());
                chk(1'b1, "R2 edge command", 0, 0);
            end else if (lv != model[ch] && lv != last_sent[ch]) begin
                chk(1'b0, "R2/R6 unexpected command ch*2+lvl", int'(ch) * 2 + int'(lv),
                    int'(ch) * 2 + int'(model[ch]));
            end
            last_sent[ch] = lv;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Drive one pin; when tracked and enabled, queue the expected command.
    task automatic drive_pin(int i, bit v, bit track);
        tick(1);
        pins[i] = v;
        if (en && model[i] != v) begin
            if (track) exp_q.push_back(i * 2 + int'(v));
            model[i] = v;
        end
    endtask

    function automatic int count_log(int from, int c, int l);
        int n = 0;
        for (int k = from; k < lg_ch.size(); k++)
            if (lg_ch[k] == c && (l < 0 || lg_lv[k] == l)) n++;
        return n;
    endfunction

    task automatic wait_idle();
        for (int k = 0; k < 200; k++) begin
            tick(1);
            if (!vld) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mk;
        int ref_ch;
        int ref_lv;
        int n;
        for (int i = 0; i < NCH; i++) begin
            model[i] = 1'b0;
            last_sent[i] = 1'b0;
        end
        repeat (4) @(posedge clk);
        #2;
        chk(vld == 1'b0, "R8 valid low in reset", int'(vld), 0);
        rst_n = 1'b1;

        // R8/R9: refresh-all after reset, with an edge overtaking the pending refreshes.
        pins[4] = 1'b1;
        model[4] = 1'b1;
        tick(20);
        chk(vld && ch == 0 && lv == 0, "R8 ch0 offered first (ch*2+lvl)", int'(ch) * 2 + int'(lv), 0);
        ready = 1'b1;
        tick(20);
        begin
            int ec[5] = '{0, 4, 1, 2, 3};
            int el[5] = '{0, 1, 0, 0, 0};
            for (int k = 0; k < 5; k++)
                chk(lg_ch.size() > k && lg_ch[k] == ec[k] && lg_lv[k] == el[k],
                    "R9 post-reset order ch*2+lvl",
                    (lg_ch.size() > k) ? lg_ch[k] * 2 + lg_lv[k] : -1, ec[k] * 2 + el[k]);
        end

        // R2: single edges and a simultaneous pair (R9 order through the queue).
        drive_pin(1, 1'b1, 1'b1); tick(20);
        drive_pin(1, 1'b0, 1'b1); tick(20);
        tick(1);
        pins[0] = 1'b1; pins[3] = 1'b1;
        model[0] = 1'b1; model[3] = 1'b1;
        exp_q.push_back(0 * 2 + 1);
        exp_q.push_back(3 * 2 + 1);
        tick(20);
        chk(exp_q.size() == 0, "R9 pair drained in order", exp_q.size(), 0);

        // R3: a two-clock glitch is dropped, a three-clock pulse is conveyed.
        mk = lg_ch.size();
        tick(1); pins[2] = 1'b1; tick(2); pins[2] = 1'b0;
        tick(30);
        chk(count_log(mk, 2, 1) == 0, "R3 short pulse ignored", count_log(mk, 2, 1), 0);
        exp_q.push_back(2 * 2 + 1);
        exp_q.push_back(2 * 2 + 0);
        tick(1); pins[2] = 1'b1; tick(3); pins[2] = 1'b0;
        tick(30);
        chk(exp_q.size() == 0, "R3 min pulse conveyed", exp_q.size(), 0);

        // R4: quiet inputs get one refresh per channel per window.
        mk = lg_ch.size();
        tick(4 * PER);
        for (int i = 0; i < NCH; i++) begin
            n = count_log(mk, i, -1);
            chk(n >= 3 && n <= 5, "R4 refresh count per channel", n, 4);
        end

        // R5: a channel toggling inside every window gets no refreshes.
        mk = lg_ch.size();
        for (int t = 0; t < 40; t++) begin
            drive_pin(2, ~pins[2], 1'b1);
            tick(39);
        end
        tick(10);
        n = count_log(mk, 2, -1);
        chk(n >= 39 && n <= 41, "R5 busy channel sends edges only", n, 40);

        // R10/R11: stalled output holds; repeated transitions collapse.
        wait_idle();
        ready = 1'b0;
        mk = lg_ch.size();
        drive_pin(1, 1'b1, 1'b0);
        tick(10);
        ref_ch = int'(ch);
        ref_lv = int'(lv);
        drive_pin(1, 1'b0, 1'b0); tick(10);
        drive_pin(1, 1'b1, 1'b0); tick(10);
        chk(vld && int'(ch) == ref_ch && int'(lv) == ref_lv, "R10 stalled command held",
            int'(ch) * 2 + int'(lv), ref_ch * 2 + ref_lv);
        ready = 1'b1;
        tick(20);
        n = count_log(mk, 1, -1);
        chk(n == 2, "R11 collapsed command count", n, 2);
        chk(lg_ch[lg_ch.size() - 1] != 1 || lg_lv[lg_lv.size() - 1] == 1 || count_log(mk, 1, 1) == 2,
            "R11 latest level sent", count_log(mk, 1, 1), 2);

        // R6: disabled stage ignores pin changes.
        wait_idle();
        tick(1);
        en = 1'b0;
        mk = lg_ch.size();
        drive_pin(3, ~pins[3], 1'b1);
        drive_pin(0, ~pins[0], 1'b1);
        tick(50);
        chk(count_log(mk, 3, int'(pins[3])) == 0, "R6 disabled change not sent",
            count_log(mk, 3, int'(pins[3])), 0);

        // R7: re-enable sends every channel's present level in order.
        mk = lg_ch.size();
        tick(1);
        en = 1'b1;
        for (int i = 0; i < NCH; i++) model[i] = pins[i];
        tick(30);
        for (int i = 0; i < NCH; i++)
            chk(lg_ch.size() > mk + i && lg_ch[mk + i] == i && lg_lv[mk + i] == int'(pins[i]),
                "R7 re-enable sweep ch*2+lvl",
                (lg_ch.size() > mk + i) ? lg_ch[mk + i] * 2 + lg_lv[mk + i] : -1,
                i * 2 + int'(pins[i]));

        tick(20);
        chk(exp_q.size() == 0, "R2 all expected edges seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule